// File: doc/BRIEF.md
# Calendar-Aligned Flow-Control Status Receiver

This block sits on the receive side of a serial flow-control status link. Each clock, a 2-bit slot arrives on `stat_in`. A user-loaded calendar decides which channel each slot belongs to. The calendar is a table of channel numbers, written through a dedicated write port. It is walked in order for a programmed number of entries, and the whole walk is repeated a programmed number of times. A single check slot follows the last repetition. The code `11` never carries status: it marks the start of a calendar round and realigns the walk to its first entry. The sender must use the same calendar contents, length and repeat count.

The latest status of every channel is held in a status store. The store can be read in two ways. A polled port returns the packed status of one aligned group of 16 channels, one cycle after the request. A transparent port presents every data slot, tagged with its channel number, in the cycle after the slot is sampled. Until the first framing slot is seen, the receiver ignores the stream and every channel reads as satisfied.

Top module: `fcs_status_rx`

## Requirements
- R1: Slot codes are 00 = starving, 01 = hungry, 10 = satisfied. The code 11 is a framing marker. It never updates any channel and never appears on the transparent port.
- R2: After reset, and until the first 11 slot, all slots are ignored. `tp_valid` stays low and every channel polls as 10.
- R3: An 11 slot restarts alignment at any point, including in the middle of a round. The next slot is calendar entry 0 of repetition 1.
- R4: Data slots are mapped in order to calendar entries 0 to `cal_len_m1`, so the length runs from 1 to 64 entries. This sequence repeats `cal_reps_m1`+1 times (1 to 16). The channel for each slot is the value stored in the current calendar entry.
- R5: After the final entry of the final repetition, exactly one check slot is consumed without any update or output. After that, non-11 slots are ignored until the next 11.
- R6: For a data slot sampled at clock edge N, the following holds after edge N: `tp_valid` is 1, `tp_chan` is the mapped channel and `tp_stat` is the slot code. `tp_valid` is 0 after every edge that sampled a non-data slot.
- R7: A `poll_req` with group g sampled at edge M raises `poll_valid` for the single cycle after edge M. In that cycle, bits [2k+1:2k] of `poll_stat` hold channel 16*g+k. `poll_valid` is 0 after any edge without a request.
- R8: Each channel holds the status of its most recent data slot. A poll sampled at the same edge as a write to one of its channels returns the value from before that write.
- R9: A write with `cal_we`=1 stores `cal_wdata` into entry `cal_waddr`. Data slots sampled after that edge use the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| stat_in | input | 2 | Serial status slot, one per clock |
| cal_we | input | 1 | Calendar entry write enable |
| cal_waddr | input | 6 | Calendar entry index to write |
| cal_wdata | input | 8 | Channel number stored in the entry |
| cal_len_m1 | input | 6 | Calendar length minus one |
| cal_reps_m1 | input | 4 | Repeat count minus one |
| poll_req | input | 1 | Poll request |
| poll_grp | input | 4 | Group of 16 channels to poll |
| poll_valid | output | 1 | Poll result valid |
| poll_stat | output | 32 | Packed status of the polled group, 2 bits per channel |
| tp_valid | output | 1 | Transparent slot valid |
| tp_chan | output | 8 | Channel of the transparent slot |
| tp_stat | output | 2 | Status code of the transparent slot |

## Verification
The bench covers the following corner cases:
- **Minimum calendar (one entry, one pass).** A design that skips the check slot would show that slot as status 10 for channel 255.
- **Full 64-entry calendar and the 16-repetition maximum.** An off-by-one counter would mis-tag the last entry or stop one pass early.
- **Framing slot in the middle of a round.** Without realignment, the following slots would carry the wrong channel tags.
- **Traffic before the first framing slot.** A receiver that starts unaligned would disturb the satisfied default.
- **Poll at the same edge as a write to the polled channel.** The bench checks the registered old-value result and the one-cycle `poll_valid` pulse.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_DATA  = 2'd1,
    ST_CHECK = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_e;

  localparam logic [1:0] FC_STARVE    = 2'b00;
  localparam logic [1:0] FC_HUNGRY    = 2'b01;
  localparam logic [1:0] FC_SATISFIED = 2'b10;
  localparam logic [1:0] FC_FRAME     = 2'b11;

endpackage

// File: rtl/fcs_cal_table.sv
module fcs_cal_table #(
  parameter int CAL_DEPTH = 64,
  parameter int CH_W      = 8,
  localparam int CAL_AW   = $clog2(CAL_DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [CAL_AW-1:0] waddr,
  input  logic [CH_W-1:0]   wdata,
  input  logic [CAL_AW-1:0] raddr,
  output logic [CH_W-1:0]   rdata
);

  logic [CH_W-1:0] mem_q [CAL_DEPTH];

  // Storage array: no reset, loaded by the user before alignment
  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/fcs_sequencer.sv
module fcs_sequencer
  import fcs_pkg::*;
#(
  parameter int CAL_AW = 6,
  parameter int REP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        stat_in,
  input  logic [CAL_AW-1:0] len_m1,
  input  logic [REP_W-1:0]  reps_m1,
  output logic [CAL_AW-1:0] idx,
  output logic              slot_we
);

  seq_state_e        state_q, state_d;
  logic [CAL_AW-1:0] idx_q, idx_d;
  logic [REP_W-1:0]  rep_q, rep_d;
  logic              is_frame;

  assign is_frame = (stat_in == FC_FRAME);
  assign slot_we  = (state_q == ST_DATA) && !is_frame;
  assign idx      = idx_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    rep_d   = rep_q;
    if (is_frame) begin
      state_d = ST_DATA;
      idx_d   = '0;
      rep_d   = '0;
    end else begin
      unique case (state_q)
        ST_DATA: begin
          if (idx_q >= len_m1) begin
            idx_d = '0;
            if (rep_q >= reps_m1) begin
              state_d = ST_CHECK;
            end else begin
              rep_d = rep_q + 1'b1;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        ST_CHECK: state_d = ST_WAIT;
        ST_HUNT:  state_d = ST_HUNT;
        ST_WAIT:  state_d = ST_WAIT;
        default:  state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      idx_q   <= '0;
      rep_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rep_q   <= rep_d;
    end
  end

  // R3: a framing slot always lands on entry 0, repetition 1
  p_frame_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_in == FC_FRAME) |=> (state_q == ST_DATA && idx_q == '0 && rep_q == '0));

  // R5: the check slot lasts exactly one slot
  p_check_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK) |=> (state_q == ST_WAIT || state_q == ST_DATA));

endmodule

// File: rtl/fcs_status_store.sv
module fcs_status_store
  import fcs_pkg::*;
#(
  parameter int CH_W     = 8,
  localparam int NCH     = 1 << CH_W,
  localparam int GRP_W   = CH_W - 4,
  localparam int GRP_CH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CH_W-1:0]   wchan,
  input  logic [1:0]        wstat,
  input  logic              poll_req,
  input  logic [GRP_W-1:0]  poll_grp,
  output logic              poll_valid,
  output logic [2*GRP_CH-1:0] poll_stat
);

  logic [NCH-1:0][1:0]   st_q;
  logic [2*GRP_CH-1:0]   grp_vec;
  logic [2*GRP_CH-1:0]   poll_stat_q, poll_stat_d;
  logic                  poll_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= {NCH{FC_SATISFIED}};
    end else if (we) begin
      st_q[wchan] <= wstat;
    end
  end

  for (genvar k = 0; k < GRP_CH; k++) begin : g_grp_rd
    assign grp_vec[2*k +: 2] = st_q[{poll_grp, 4'(k)}];
  end

  assign poll_stat_d = poll_req ? grp_vec : poll_stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_valid_q <= 1'b0;
      poll_stat_q  <= '0;
    end else begin
      poll_valid_q <= poll_req;
      poll_stat_q  <= poll_stat_d;
    end
  end

  assign poll_valid = poll_valid_q;
  assign poll_stat  = poll_stat_q;

  // R7: one-cycle registered poll response
  p_poll_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |=> poll_valid);
  p_poll_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_req |=> !poll_valid);

endmodule

// File: rtl/fcs_status_rx.sv
module fcs_status_rx
  import fcs_pkg::*;
#(
  parameter int CH_W      = 8,
  parameter int CAL_DEPTH = 64,
  parameter int REP_W     = 4,
  localparam int CAL_AW   = $clog2(CAL_DEPTH),
  localparam int GRP_W    = CH_W - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        stat_in,
  input  logic              cal_we,
  input  logic [CAL_AW-1:0] cal_waddr,
  input  logic [CH_W-1:0]   cal_wdata,
  input  logic [CAL_AW-1:0] cal_len_m1,
  input  logic [REP_W-1:0]  cal_reps_m1,
  input  logic              poll_req,
  input  logic [GRP_W-1:0]  poll_grp,
  output logic              poll_valid,
  output logic [31:0]       poll_stat,
  output logic              tp_valid,
  output logic [CH_W-1:0]   tp_chan,
  output logic [1:0]        tp_stat
);

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [CAL_AW-1:0] cur_idx;
  logic [CH_W-1:0]   cur_chan;
  logic              slot_we;

  fcs_cal_table #(.CAL_DEPTH(CAL_DEPTH), .CH_W(CH_W)) u_cal (
    .clk   (clk),
    .we    (cal_we),
    .waddr (cal_waddr),
    .wdata (cal_wdata),
    .raddr (cur_idx),
    .rdata (cur_chan)
  );

  fcs_sequencer #(.CAL_AW(CAL_AW), .REP_W(REP_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .stat_in (stat_in),
    .len_m1  (cal_len_m1),
    .reps_m1 (cal_reps_m1),
    .idx     (cur_idx),
    .slot_we (slot_we)
  );

  fcs_status_store #(.CH_W(CH_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .we         (slot_we),
    .wchan      (cur_chan),
    .wstat      (stat_in),
    .poll_req   (poll_req),
    .poll_grp   (poll_grp),
    .poll_valid (poll_valid),
    .poll_stat  (poll_stat)
  );

  logic            tp_valid_q, tp_valid_d;
  logic [CH_W-1:0] tp_chan_q, tp_chan_d;
  logic [1:0]      tp_stat_q, tp_stat_d;

  always_comb begin
    tp_valid_d = slot_we;
    tp_chan_d  = slot_we ? cur_chan : tp_chan_q;
    tp_stat_d  = slot_we ? stat_in  : tp_stat_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tp_valid_q <= 1'b0;
      tp_chan_q  <= '0;
      tp_stat_q  <= FC_SATISFIED;
    end else begin
      tp_valid_q <= tp_valid_d;
      tp_chan_q  <= tp_chan_d;
      tp_stat_q  <= tp_stat_d;
    end
  end

  assign tp_valid = tp_valid_q;
  assign tp_chan  = tp_chan_q;
  assign tp_stat  = tp_stat_q;

  // R1: framing marker never reaches the transparent port
  p_no_frame_pass_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_in == FC_FRAME) |=> !tp_valid);

  // R6: a passed slot never carries the framing code
  p_tp_code_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tp_valid |-> (tp_stat != FC_FRAME));

endmodule

// File: tb/tb_fcs_status_rx.sv
module tb_fcs_status_rx;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  stat_in;
  logic        cal_we;
  logic [5:0]  cal_waddr;
  logic [7:0]  cal_wdata;
  logic [5:0]  cal_len_m1;
  logic [3:0]  cal_reps_m1;
  logic        poll_req;
  logic [3:0]  poll_grp;
  logic        poll_valid;
  logic [31:0] poll_stat;
  logic        tp_valid;
  logic [7:0]  tp_chan;
  logic [1:0]  tp_stat;

  always #10 clk = ~clk;

  fcs_status_rx dut (
    .clk(clk), .rst_n(rst_n), .stat_in(stat_in),
    .cal_we(cal_we), .cal_waddr(cal_waddr), .cal_wdata(cal_wdata),
    .cal_len_m1(cal_len_m1), .cal_reps_m1(cal_reps_m1),
    .poll_req(poll_req), .poll_grp(poll_grp),
    .poll_valid(poll_valid), .poll_stat(poll_stat),
    .tp_valid(tp_valid), .tp_chan(tp_chan), .tp_stat(tp_stat)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [1:0] mdl [256];
  logic [7:0] calm [64];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] grp_exp(input int g);
    logic [31:0] v;
    for (int k = 0; k < 16; k++) v[2*k +: 2] = mdl[g*16 + k];
    return v;
  endfunction

  task automatic slot(input logic [1:0] s, input bit ev, input logic [7:0] ech, input string req);
    @(negedge clk);
    stat_in = s;
    @(posedge clk);
    #1;
    chk({31'd0, tp_valid}, {31'd0, ev}, req, "tp_valid");
    if (ev) begin
      chk({24'd0, tp_chan}, {24'd0, ech}, req, "tp_chan");
      chk({30'd0, tp_stat}, {30'd0, s}, req, "tp_stat");
    end
  endtask

  task automatic poll(input int g, input string req);
    @(negedge clk);
    poll_req = 1'b1;
    poll_grp = 4'(g);
    @(posedge clk);
    #1;
    chk({31'd0, poll_valid}, 32'd1, req, "poll_valid high");
    chk(poll_stat, grp_exp(g), req, "poll_stat");
    @(negedge clk);
    poll_req = 1'b0;
    @(posedge clk);
    #1;
    chk({31'd0, poll_valid}, 32'd0, "R7", "poll_valid one cycle");
  endtask

  task automatic prog(input int len, input int reps);
    for (int e = 0; e < len; e++) begin
      @(negedge clk);
      cal_we = 1'b1;
      cal_waddr = 6'(e);
      cal_wdata = calm[e];
    end
    @(negedge clk);
    cal_we = 1'b0;
    cal_len_m1 = 6'(len - 1);
    cal_reps_m1 = 4'(reps - 1);
  endtask

  // one framed round: framing, data, check slot, then ignored slots
  task automatic round(input int len, input int reps, input int seed);
    slot(2'b11, 1'b0, 8'd0, "R3");
    for (int r = 0; r < reps; r++) begin
      for (int e = 0; e < len; e++) begin
        logic [1:0] s;
        s = 2'((r + e + seed) % 3);
        slot(s, 1'b1, calm[e], "R4");
        mdl[calm[e]] = s;
      end
    end
    slot(2'b10, 1'b0, 8'd0, "R5");
    slot(2'b00, 1'b0, 8'd0, "R5");
    slot(2'b01, 1'b0, 8'd0, "R5");
  endtask

  task automatic poll_all(input string req);
    for (int g = 0; g < 16; g++) poll(g, req);
  endtask

  task automatic t_reset;
    chk({31'd0, tp_valid}, 32'd0, "R2", "tp_valid at reset");
    chk({31'd0, poll_valid}, 32'd0, "R7", "poll_valid at reset");
    poll(0, "R2");
    poll(15, "R2");
    slot(2'b00, 1'b0, 8'd0, "R2");
    slot(2'b01, 1'b0, 8'd0, "R2");
    poll(0, "R2");
  endtask

  task automatic t_basic;
    calm[0] = 8'd3; calm[1] = 8'd17; calm[2] = 8'd0; calm[3] = 8'd40;
    prog(4, 2);
    round(4, 2, 0);
    poll_all("R1 R8");
  endtask

  task automatic t_realign;
    slot(2'b11, 1'b0, 8'd0, "R3");
    slot(2'b00, 1'b1, calm[0], "R6");
    mdl[calm[0]] = 2'b00;
    slot(2'b01, 1'b1, calm[1], "R6");
    mdl[calm[1]] = 2'b01;
    round(4, 2, 1);
    poll(0, "R3");
    poll(1, "R3");
  endtask

  task automatic t_min;
    calm[0] = 8'd255;
    prog(1, 1);
    round(1, 1, 1);
    poll(15, "R5");
  endtask

  task automatic t_max_len;
    for (int e = 0; e < 64; e++) calm[e] = 8'(e * 4 + 1);
    prog(64, 3);
    round(64, 3, 2);
    poll_all("R4");
  endtask

  task automatic t_max_reps;
    calm[0] = 8'd7; calm[1] = 8'd8;
    prog(2, 16);
    round(2, 16, 0);
    poll(0, "R4");
  endtask

  task automatic t_reprog;
    calm[0] = 8'd99; calm[1] = 8'd8;
    prog(2, 1);
    round(2, 1, 2);
    poll(6, "R9");
  endtask

  task automatic t_poll_race;
    logic [31:0] old_v;
    calm[0] = 8'd200;
    prog(1, 1);
    old_v = grp_exp(12);
    @(negedge clk);
    stat_in = 2'b11;
    @(negedge clk);
    stat_in = 2'b00;
    poll_req = 1'b1;
    poll_grp = 4'd12;
    @(posedge clk);
    #1;
    chk(poll_stat, old_v, "R8", "poll same edge as write");
    chk({31'd0, tp_valid}, 32'd1, "R6", "tp_valid race slot");
    mdl[200] = 2'b00;
    @(negedge clk);
    poll_req = 1'b0;
    stat_in = 2'b10;
    @(negedge clk);
    stat_in = 2'b00;
    poll(12, "R8");
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 2'b10;
    rst_n = 1'b0;
    stat_in = 2'b00;
    cal_we = 1'b0;
    cal_waddr = '0;
    cal_wdata = '0;
    cal_len_m1 = '0;
    cal_reps_m1 = '0;
    poll_req = 1'b0;
    poll_grp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_basic;
    t_realign;
    t_min;
    t_max_len;
    t_max_reps;
    t_reprog;
    t_poll_race;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule